// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block converts an 8-bit unsigned binary number into three packed decimal digits: hundreds, tens and units. It uses the shift-and-add-3 method, but does only one shift step per clock edge, so its combinational depth is a single digit adjustment instead of a long unrolled chain.

A client raises a one-cycle start strobe together with the value while the block is idle. The three most significant bits of the value are preloaded into the units digit. The other five bits are then shifted in, one per clock. Before each shift, every lower digit that holds a value above 4 is increased by 3. The hundreds digit can never exceed 2, so it gets no adjustment. A one-cycle done pulse marks the new result. The result register keeps its value until the next conversion completes.

Top module: `bin_to_dec_iter`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `busy_o` and `done_o` are 0 and `bcd_o` is all zeros.
- R2: A high `start_i` sampled while `busy_o` is low captures `bin_i` and sets `busy_o` high on that same edge.
- R3: After a conversion, `bcd_o[11:8]` holds the hundreds digit, `bcd_o[7:4]` holds the tens digit and `bcd_o[3:0]` holds the units digit of the captured value. Digit adjustment (add 3 to a digit above 4) happens before each shift, and never after the last one.
- R4: `done_o` rises on the fifth rising edge after the edge that accepted the start. That makes six clocks in total: one load and five shifts. `busy_o` stays high in between.
- R5: `done_o` is high for exactly one cycle, and `busy_o` is low whenever `done_o` is high.
- R6: A high `start_i` while `busy_o` is high is ignored. The running conversion completes with the value that was first captured.
- R7: `bcd_o` changes only on the edge that raises `done_o`, and stays unchanged during a later conversion until that conversion's done edge.
- R8: In every result, `bcd_o[11:10]` are 0 and `bcd_o[0]` equals bit 0 of the captured input.
- R9: Each conversion starts from a cleared working register, so a result never depends on the previous conversion (for example, 0 after 255 gives all zeros).
- R10: Every digit of `bcd_o` is at most 9, and the hundreds digit is at most 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, honoured only while idle |
| bin_i | input | 8 | Unsigned binary value to convert |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a new result is present |
| bcd_o | output | 12 | Packed result: hundreds [11:8], tens [7:4], units [3:0] |

## Verification
The bench builds the block with its default parameters: an 8-bit input, 4-bit digits, three digits and three preloaded bits. With these values the whole input space of 256 values is small enough to sweep exhaustively, and the bench adds seeded random values and directed digit-boundary values such as 4, 5, 9, 99, 100 and 199. It also sends a start strobe in the middle of each conversion and watches the latency, so both the five-step sequencing and the rule that ignores a busy start are exercised on every value.

// File: rtl/b2d_pkg.sv
// Shared definitions for the sequential binary-to-decimal converter.
// Assumes: nothing beyond a synthesizable SystemVerilog flow.
package b2d_pkg;
    // Controller states: waiting for a start, or stepping through shifts
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } b2d_state_e;
endpackage

// File: rtl/dec_digit_adjust.sv
// Conditional add-3 for one decimal digit of the shift-and-add-3 method.
// Values 0..4 pass unchanged; values 5..9 become 8..12.
// Assumes: the input digit never exceeds 9 (guaranteed by the algorithm).
module dec_digit_adjust #(
    parameter int DIG_W = 4
) (
    input  logic [DIG_W-1:0] dig_i,
    output logic [DIG_W-1:0] dig_o
);
    localparam logic [DIG_W-1:0] THRESH = DIG_W'(4);
    localparam logic [DIG_W-1:0] OFFSET = DIG_W'(3);

    // Purpose: add the offset when the digit would overflow after doubling
    always_comb begin
        if (dig_i > THRESH) dig_o = dig_i + OFFSET;
        else                dig_o = dig_i;
    end
endmodule

// File: rtl/b2d_seq_ctrl.sv
// Sequencer for the converter: accepts a start while idle, then runs
// STEPS shift cycles and raises done on the edge of the final shift.
// Assumes: start_i is ignored while a conversion runs.
module b2d_seq_ctrl
    import b2d_pkg::*;
#(
    parameter int STEPS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

    b2d_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Purpose: decode control strobes from state and step counter
    always_comb begin
        load_o = start_i && (state_q == ST_IDLE);
        step_o = (state_q == ST_SHIFT);
        last_o = step_o && (cnt_q == LAST_CNT);
    end

    // Purpose: advance state, step counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last_o;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SHIFT;
                        cnt_q   <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (cnt_q == LAST_CNT) state_q <= ST_IDLE;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == ST_SHIFT);
    assign done_o = done_q;
endmodule

// File: rtl/b2d_shift_path.sv
// Datapath of the converter: working register, input shift register,
// per-digit adjustment and the result register.
// Assumes: load_i and step_i are never high together.
module b2d_shift_path #(
    parameter int IN_W     = 8,
    parameter int DIG_W    = 4,
    parameter int NUM_DIG  = 3,
    parameter int PRE_BITS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic                       step_i,
    input  logic                       last_i,
    input  logic [IN_W-1:0]            bin_i,
    output logic [NUM_DIG*DIG_W-1:0]   bcd_o
);
    localparam int OUT_W = NUM_DIG * DIG_W;
    localparam int STEPS = IN_W - PRE_BITS;

    logic [OUT_W-1:0] work_q;
    logic [OUT_W-1:0] adj_w;
    logic [OUT_W-1:0] shifted_w;
    logic [STEPS-1:0] src_q;
    logic [OUT_W-1:0] res_q;

    // Lower digits get the add-3 correction; the top digit stays below 5
    for (genvar g = 0; g < NUM_DIG - 1; g++) begin : g_adj
        dec_digit_adjust #(.DIG_W(DIG_W)) u_adj (
            .dig_i (work_q[g*DIG_W +: DIG_W]),
            .dig_o (adj_w[g*DIG_W +: DIG_W])
        );
    end
    assign adj_w[OUT_W-1 -: DIG_W] = work_q[OUT_W-1 -: DIG_W];

    // Correct first, then move one bit left and bring in the next input bit
    assign shifted_w = {adj_w[OUT_W-2:0], src_q[STEPS-1]};

    // Purpose: clear-and-preload on start, shift once per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            src_q  <= '0;
        end else if (load_i) begin
            work_q <= {{(OUT_W-PRE_BITS){1'b0}}, bin_i[IN_W-1 -: PRE_BITS]};
            src_q  <= bin_i[STEPS-1:0];
        end else if (step_i) begin
            work_q <= shifted_w;
            src_q  <= src_q << 1;
        end
    end

    // Purpose: publish the result on the final shift only
    always_ff @(posedge clk) begin
        if (!rst_n)               res_q <= '0;
        else if (step_i && last_i) res_q <= shifted_w;
    end

    assign bcd_o = res_q;
endmodule

// File: rtl/bin_to_dec_iter.sv
// Top level of the sequential binary-to-decimal converter.
// Assumes: synchronous active-low reset; one start strobe per conversion.
module bin_to_dec_iter #(
    parameter int IN_W     = 8,
    parameter int DIG_W    = 4,
    parameter int NUM_DIG  = 3,
    parameter int PRE_BITS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [IN_W-1:0]          bin_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [NUM_DIG*DIG_W-1:0] bcd_o
);
    localparam int STEPS = IN_W - PRE_BITS;

    logic load_w;
    logic step_w;
    logic last_w;

    b2d_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load_w),
        .step_o  (step_w),
        .last_o  (last_w),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    b2d_shift_path #(
        .IN_W     (IN_W),
        .DIG_W    (DIG_W),
        .NUM_DIG  (NUM_DIG),
        .PRE_BITS (PRE_BITS)
    ) u_path (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .step_i (step_w),
        .last_i (last_w),
        .bin_i  (bin_i),
        .bcd_o  (bcd_o)
    );
endmodule

// File: rtl/bin_to_dec_iter_chk.sv
// Property checker for bin_to_dec_iter, attached with bind.
// Assumes: default geometry of three 4-bit digits and an 8-bit input.
module bin_to_dec_iter_chk #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12,
    parameter int STEPS = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [IN_W-1:0]  bin_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [OUT_W-1:0] bcd_o
);
    logic [IN_W-1:0] cap_q;
    logic [7:0]      lat_q;
    int              val_w;

    // Purpose: remember the accepted value and count cycles since its start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            cap_q <= bin_i;
            lat_q <= '0;
        end else if (busy_o) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    assign val_w = int'(bcd_o[11:8]) * 100 + int'(bcd_o[7:4]) * 10 + int'(bcd_o[3:0]);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    p_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (val_w == int'(cap_q)));
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == 8'(STEPS)));
    p_busy_until_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(bcd_o));
    p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bcd_o[11:10] == 2'b00 && bcd_o[0] == cap_q[0]));
    p_digit_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd_o[11:8] <= 4'd2 && bcd_o[7:4] <= 4'd9 && bcd_o[3:0] <= 4'd9));
endmodule

bind bin_to_dec_iter bin_to_dec_iter_chk #(
    .IN_W  (IN_W),
    .OUT_W (NUM_DIG * DIG_W),
    .STEPS (IN_W - PRE_BITS)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .bin_i   (bin_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .bcd_o   (bcd_o)
);

// File: tb/bin_to_dec_iter_tb_top.sv
`timescale 1ns/1ps
module bin_to_dec_iter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  bin_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [11:0] bcd_o;

    int checks = 0;
    int errors = 0;
    logic [11:0] prev_res = '0;

    always #2 clk = ~clk;

    bin_to_dec_iter dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .bin_i   (bin_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .bcd_o   (bcd_o)
    );

    function automatic logic [11:0] exp_bcd(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One conversion, with a start strobe injected mid-run (must be ignored)
    task automatic convert(input int v);
        int cnt;
        logic [11:0] e;
        e = exp_bcd(v);
        @(negedge clk);
        start_i = 1'b1;
        bin_i   = 8'(v);
        @(negedge clk);
        start_i = 1'b0;
        bin_i   = '0;
        check("R2 busy after start", busy_o === 1'b1, 32'(busy_o), 1);
        cnt = 0;
        while (done_o !== 1'b1 && cnt < 12) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) check("R7 result held", bcd_o === prev_res, 32'(bcd_o), 32'(prev_res));
            if (cnt == 2) begin
                start_i = 1'b1;          // R6: ignored start
                bin_i   = ~8'(v);
            end
            if (cnt == 3) begin
                start_i = 1'b0;
                bin_i   = '0;
            end
            if (cnt < 5 && done_o !== 1'b1)
                check("R4 busy in run", busy_o === 1'b1, 32'(busy_o), 1);
        end
        check("R4 latency", cnt == 5, 32'(cnt), 5);
        check("R3 R6 value", bcd_o === e && !$isunknown(bcd_o), 32'(bcd_o), 32'(e));
        check("R8 fixed bits", bcd_o[11:10] === 2'b00 && bcd_o[0] === 1'(v),
              32'({bcd_o[11:10], bcd_o[0]}), 32'({2'b00, 1'(v)}));
        check("R10 ranges", bcd_o[11:8] <= 4'd2 && bcd_o[7:4] <= 4'd9 && bcd_o[3:0] <= 4'd9,
              32'(bcd_o), 32'(e));
        check("R5 done idle", busy_o === 1'b0, 32'(busy_o), 0);
        @(negedge clk);
        check("R5 single pulse", done_o === 1'b0, 32'(done_o), 0);
        prev_res = bcd_o;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int dir [12] = '{0, 1, 4, 5, 9, 10, 99, 100, 199, 200, 255, 0};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset busy", busy_o === 1'b0, 32'(busy_o), 0);
        check("R1 reset done", done_o === 1'b0, 32'(done_o), 0);
        check("R1 reset result", bcd_o === 12'h000, 32'(bcd_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", busy_o === 1'b0 && done_o === 1'b0 && bcd_o === 12'h000,
              32'(bcd_o), 0);
        // Directed corners; 255 then 0 shows no carry-over (R9)
        foreach (dir[i]) convert(dir[i]);
        check("R9 cleared after 255", bcd_o === 12'h000, 32'(bcd_o), 0);
        for (int v = 0; v < 256; v++) convert(v);
        for (int k = 0; k < 40; k++) convert(int'($urandom_range(255, 0)));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule